// File: doc/BRIEF.md
# SPI Packet Length and Loop Sequencer

This block decides how many bytes an SPI master moves in one transfer. It splits the transfer into equal packets using two programmed fields: the number of bytes per packet and the number of packets, each written as the count minus one. An activate command latches these fields and starts the transfer from idle. The sequencer then asks the serial timing generator for one byte at a time and counts each acknowledged byte against the packet length and the packet count.

Between packets the sequencer does one of three things. By default it drops chip select and waits a programmed idle time. In streaming (non-idle) mode it carries straight on with chip select still asserted. With pause enabled it stops and holds a paused status until a resume command arrives. After the final byte it returns to idle and sets a done status bit. Two enables gate the done and paused status bits onto a single interrupt line. A software reset command aborts the transfer at any point.

Top module: `spi_pkt_seq`

## Requirements
- R1: An activate command accepted in idle raises `cs_active` and `byte_req` from the next cycle onward and clears the done bit. After reset, `cs_active`, `byte_req`, `status` and `irq` are all 0.
- R2: A transfer consists of `pkt_loop_m1`+1 packets, each of `pkt_len_m1`+1 bytes. A byte counts when `byte_ack` is high in a cycle where `byte_req` is high. The cycle after the last byte, the sequencer is idle with `status[0]` (done) set.
- R3: With streaming and pause both off, `cs_active` and `byte_req` are low for exactly `cs_idle_m1`+1 cycles between two packets.
- R4: With streaming on and pause off, `cs_active` stays high from the first byte to the last, with no gap between packets.
- R5: With pause on, the sequencer enters a paused state after every packet except the last. In that state `cs_active` is low and `status[1]` (paused) is set. A resume command clears `status[1]` and restarts bytes on the next cycle.
- R6: The done bit `status[0]` is cleared by `status_rd_clr` or by an accepted activate. The paused bit `status[1]` is cleared by `status_rd_clr` or by an accepted resume. A bit being set in a cycle wins over a clear in that same cycle.
- R7: `irq` is high exactly when (`status[0]` and `finish_ie`) or (`status[1]` and `pause_ie`).
- R8: `cmd_swrst` returns the sequencer to idle on the next cycle and clears both status bits. It takes priority over every other command.
- R9: An activate command is ignored unless the sequencer is idle, and a resume command is ignored unless it is paused.
- R10: The length, loop, idle, pause and streaming settings are sampled when the activate command is accepted. Changing them during a transfer has no effect on it.
- R11: The field extremes work: one packet of 65536 bytes, and 256 packets of one byte each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_act | input | 1 | Activate command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| cmd_swrst | input | 1 | Software reset / abort pulse |
| status_rd_clr | input | 1 | Read-to-clear strobe for both status bits |
| pkt_len_m1 | input | 16 | Bytes per packet minus one |
| pkt_loop_m1 | input | 8 | Packets per transfer minus one |
| cs_idle_m1 | input | 8 | Inter-packet idle cycles minus one |
| pause_en | input | 1 | Pause after each non-final packet |
| nonidle_en | input | 1 | Streaming mode, no gap between packets |
| finish_ie | input | 1 | Done interrupt enable |
| pause_ie | input | 1 | Pause interrupt enable |
| byte_ack | input | 1 | Timing generator finished a byte |
| cs_active | output | 1 | Chip select asserted (logical, active high) |
| byte_req | output | 1 | Request for the next byte |
| status | output | 2 | Bit 0 done, bit 1 paused |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the rules that hold locally. The byte counter never passes the latched length, and the packet counter never passes the latched loop count. Chip select is off while the paused bit is set, and an interrupt always has a status bit behind it. The latched settings do not change once a transfer is under way, and both software reset and a resume issued while idle leave the sequencer idle. Three things can only be shown by the bench's scenarios, which run against a behavioural model: that the total byte count equals the product of the two fields, that the idle gap has the programmed length, and that streaming leaves no gap. The same holds for the two field extremes and for an activate that arrives mid-transfer with new settings.

// File: rtl/spi_pkt_seq_pkg.sv
package spi_pkt_seq_pkg;

    localparam int SQ_LEN_W  = 16;
    localparam int SQ_LOOP_W = 8;
    localparam int SQ_IDLE_W = 8;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_XFER  = 2'd1,
        SQ_GAP   = 2'd2,
        SQ_PAUSE = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic [SQ_LEN_W-1:0]  len;
        logic [SQ_LOOP_W-1:0] loop;
        logic [SQ_IDLE_W-1:0] idle;
        logic                 pause_en;
        logic                 nonidle;
    } sq_cfg_t;

    typedef struct packed {
        logic act;
        logic resume;
        logic swrst;
    } sq_cmd_t;

    // Gap-free step to the next packet: neither pausing nor idling.
    function automatic logic sq_stream_on(sq_cfg_t c);
        return c.nonidle && !c.pause_en;
    endfunction

endpackage

// File: rtl/spi_pkt_seq_count.sv
module spi_pkt_seq_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] value,
    output logic         at_limit
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value    = cnt_q;
    assign at_limit = (cnt_q == limit);
endmodule

// File: rtl/spi_pkt_seq_gap.sv
module spi_pkt_seq_gap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (load) begin
            tmr_q <= load_val;
        end else if (run && tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign expired = (tmr_q == '0);
endmodule

// File: rtl/spi_pkt_seq_status.sv
module spi_pkt_seq_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       swrst,
    input  logic       rd_clr,
    input  logic       done_set,
    input  logic       done_clr,
    input  logic       pause_set,
    input  logic       pause_clr,
    input  logic       finish_ie,
    input  logic       pause_ie,
    output logic [1:0] status,
    output logic       irq
);
    logic done_q;
    logic paused_q;

    always_ff @(posedge clk) begin
        if (rst || swrst) begin
            done_q <= 1'b0;
        end else if (done_set) begin
            done_q <= 1'b1;
        end else if (rd_clr || done_clr) begin
            done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || swrst) begin
            paused_q <= 1'b0;
        end else if (pause_set) begin
            paused_q <= 1'b1;
        end else if (rd_clr || pause_clr) begin
            paused_q <= 1'b0;
        end
    end

    assign status = {paused_q, done_q};
    assign irq    = (done_q && finish_ie) || (paused_q && pause_ie);
endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
    import spi_pkt_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_act,
    input  logic                 cmd_resume,
    input  logic                 cmd_swrst,
    input  logic                 status_rd_clr,
    input  logic [SQ_LEN_W-1:0]  pkt_len_m1,
    input  logic [SQ_LOOP_W-1:0] pkt_loop_m1,
    input  logic [SQ_IDLE_W-1:0] cs_idle_m1,
    input  logic                 pause_en,
    input  logic                 nonidle_en,
    input  logic                 finish_ie,
    input  logic                 pause_ie,
    input  logic                 byte_ack,
    output logic                 cs_active,
    output logic                 byte_req,
    output logic [1:0]           status,
    output logic                 irq
);
    sq_state_e st_q, st_d;
    sq_cfg_t   cfg_q;
    sq_cmd_t   cmd;

    logic [SQ_LEN_W-1:0]  byte_val;
    logic [SQ_LOOP_W-1:0] pkt_val;
    logic byte_at_lim, pkt_at_lim, gap_done;
    logic take_act, take_res, ack_hit, pkt_end, xfer_end;
    logic to_gap, to_pause;

    assign cmd = '{act: cmd_act, resume: cmd_resume, swrst: cmd_swrst};

    assign take_act = cmd.act    && !cmd.swrst && (st_q == SQ_IDLE);
    assign take_res = cmd.resume && !cmd.swrst && (st_q == SQ_PAUSE);
    assign ack_hit  = (st_q == SQ_XFER) && byte_ack;
    assign pkt_end  = ack_hit && byte_at_lim;
    assign xfer_end = pkt_end && pkt_at_lim;
    assign to_pause = pkt_end && !xfer_end && cfg_q.pause_en;
    assign to_gap   = pkt_end && !xfer_end && !cfg_q.pause_en && !cfg_q.nonidle;

    // Settings are captured once, when the transfer is accepted.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (take_act) begin
            cfg_q <= '{len: pkt_len_m1, loop: pkt_loop_m1, idle: cs_idle_m1,
                       pause_en: pause_en, nonidle: nonidle_en};
        end
    end

    spi_pkt_seq_count #(.W(SQ_LEN_W)) u_byte_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cmd.swrst || take_act || pkt_end),
        .inc      (ack_hit),
        .limit    (cfg_q.len),
        .value    (byte_val),
        .at_limit (byte_at_lim)
    );

    spi_pkt_seq_count #(.W(SQ_LOOP_W)) u_pkt_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cmd.swrst || take_act),
        .inc      (pkt_end && !pkt_at_lim),
        .limit    (cfg_q.loop),
        .value    (pkt_val),
        .at_limit (pkt_at_lim)
    );

    spi_pkt_seq_gap #(.W(SQ_IDLE_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (to_gap),
        .load_val (cfg_q.idle),
        .run      (st_q == SQ_GAP),
        .expired  (gap_done)
    );

    always_comb begin
        st_d = st_q;
        if (cmd.swrst) begin
            st_d = SQ_IDLE;
        end else begin
            unique case (st_q)
                SQ_IDLE:  if (take_act) st_d = SQ_XFER;
                SQ_XFER: begin
                    if (xfer_end)                  st_d = SQ_IDLE;
                    else if (to_pause)             st_d = SQ_PAUSE;
                    else if (to_gap)               st_d = SQ_GAP;
                    else if (sq_stream_on(cfg_q))  st_d = SQ_XFER;
                end
                SQ_GAP:   if (gap_done) st_d = SQ_XFER;
                SQ_PAUSE: if (take_res) st_d = SQ_XFER;
                default:  st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    spi_pkt_seq_status u_status (
        .clk       (clk),
        .rst       (rst),
        .swrst     (cmd.swrst),
        .rd_clr    (status_rd_clr),
        .done_set  (xfer_end),
        .done_clr  (take_act),
        .pause_set (to_pause),
        .pause_clr (take_res),
        .finish_ie (finish_ie),
        .pause_ie  (pause_ie),
        .status    (status),
        .irq       (irq)
    );

    assign cs_active = (st_q == SQ_XFER);
    assign byte_req  = (st_q == SQ_XFER);
endmodule

// File: rtl/spi_pkt_seq_chk.sv
module spi_pkt_seq_chk
    import spi_pkt_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_act,
    input logic                 cmd_resume,
    input logic                 cmd_swrst,
    input logic                 cs_active,
    input logic [1:0]           status,
    input logic                 irq,
    input sq_state_e            st,
    input logic [SQ_LEN_W-1:0]  byte_val,
    input logic [SQ_LOOP_W-1:0] pkt_val,
    input logic [SQ_LEN_W-1:0]  len_q,
    input logic [SQ_LOOP_W-1:0] loop_q
);
    a_r1_start: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && cmd_act && !cmd_swrst) |=> (cs_active && !status[0]));

    a_r2_byte_bound: assert property (@(posedge clk) disable iff (rst)
        byte_val <= len_q);

    a_r2_pkt_bound: assert property (@(posedge clk) disable iff (rst)
        pkt_val <= loop_q);

    a_r5_pause_cs_off: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> !cs_active);

    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != 2'b00));

    a_r8_swrst_abort: assert property (@(posedge clk) disable iff (rst)
        cmd_swrst |=> (!cs_active && status == 2'b00));

    a_r9_resume_in_idle: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && cmd_resume && !cmd_act) |=> (st == SQ_IDLE));

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (st != SQ_IDLE) |=> ($stable(len_q) && $stable(loop_q)));
endmodule

bind spi_pkt_seq spi_pkt_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_act    (cmd_act),
    .cmd_resume (cmd_resume),
    .cmd_swrst  (cmd_swrst),
    .cs_active  (cs_active),
    .status     (status),
    .irq        (irq),
    .st         (st_q),
    .byte_val   (byte_val),
    .pkt_val    (pkt_val),
    .len_q      (cfg_q.len),
    .loop_q     (cfg_q.loop)
);

// File: tb/spi_pkt_seq_test.sv
module spi_pkt_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_act = 0, cmd_resume = 0, cmd_swrst = 0, status_rd_clr = 0;
    logic [15:0] pkt_len_m1 = 0;
    logic [7:0]  pkt_loop_m1 = 0, cs_idle_m1 = 0;
    logic pause_en = 0, nonidle_en = 0, finish_ie = 0, pause_ie = 0;
    logic byte_ack = 0;
    logic cs_active, byte_req, irq;
    logic [1:0] status;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int ack_mode = 1;
    int nbytes = 0, ngap = 0;
    bit in_x = 0, prev_req = 0;

    // behavioural reference state
    int m_st = 0, m_b = 0, m_p = 0, m_t = 0;
    int m_L = 0, m_N = 0, m_I = 0;
    bit m_pe = 0, m_ni = 0, m_done = 0, m_pf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pkt_seq uut (
        .clk(clk), .rst(rst), .cmd_act(cmd_act), .cmd_resume(cmd_resume),
        .cmd_swrst(cmd_swrst), .status_rd_clr(status_rd_clr),
        .pkt_len_m1(pkt_len_m1), .pkt_loop_m1(pkt_loop_m1), .cs_idle_m1(cs_idle_m1),
        .pause_en(pause_en), .nonidle_en(nonidle_en), .finish_ie(finish_ie),
        .pause_ie(pause_ie), .byte_ack(byte_ack), .cs_active(cs_active),
        .byte_req(byte_req), .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, actual, expected, $time);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (ack_mode == 0)      byte_ack <= 1'b0;
        else if (ack_mode == 1) byte_ack <= 1'b1;
        else                    byte_ack <= ~byte_ack;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            report();
        end
    end

    // reference model step, then per-cycle comparison
    always @(posedge clk) begin
        bit aa, ar, ds, ps;
        if (rst) begin
            m_st = 0; m_done = 0; m_pf = 0;
        end else if (cmd_swrst) begin
            m_st = 0; m_done = 0; m_pf = 0;
        end else begin
            aa = cmd_act && (m_st == 0);
            ar = cmd_resume && (m_st == 3);
            ds = 0; ps = 0;
            case (m_st)
                0: if (aa) begin
                    m_L = pkt_len_m1; m_N = pkt_loop_m1; m_I = cs_idle_m1;
                    m_pe = pause_en; m_ni = nonidle_en; m_b = 0; m_p = 0; m_st = 1;
                end
                1: if (byte_ack) begin
                    if (m_b == m_L) begin
                        m_b = 0;
                        if (m_p == m_N) begin m_st = 0; ds = 1; end
                        else begin
                            m_p++;
                            if (m_pe) begin m_st = 3; ps = 1; end
                            else if (!m_ni) begin m_st = 2; m_t = m_I; end
                        end
                    end else m_b++;
                end
                2: if (m_t == 0) m_st = 1; else m_t--;
                3: if (ar) m_st = 1;
                default: m_st = 0;
            endcase
            if (ds) m_done = 1; else if (status_rd_clr || aa) m_done = 0;
            if (ps) m_pf = 1;   else if (status_rd_clr || ar) m_pf = 0;
        end
        #1;
        chk("R2 cs_active model", cs_active, m_st == 1);
        chk("R2 byte_req model", byte_req, m_st == 1);
        chk("R6 status model", status, {m_pf, m_done});
        chk("R7 irq model", irq, (m_done && finish_ie) || (m_pf && pause_ie));
        if (prev_req && byte_ack) nbytes++;
        prev_req = byte_req;
        if (status[0]) in_x = 0;
        if (in_x && !cs_active && !status[1]) ngap++;
    end

    task automatic start(input int len, input int loop, input int idle,
                         input bit pe, input bit ni);
        @(negedge clk);
        pkt_len_m1 = len[15:0]; pkt_loop_m1 = loop[7:0]; cs_idle_m1 = idle[7:0];
        pause_en = pe; nonidle_en = ni; cmd_act = 1;
        nbytes = 0; ngap = 0; in_x = 1;
        @(negedge clk);
        cmd_act = 0;
    endtask

    task automatic wait_done();
        while (!status[0]) @(negedge clk);
    endtask

    task automatic wait_paused();
        while (!status[1]) @(negedge clk);
    endtask

    task automatic pulse_resume();
        @(negedge clk); cmd_resume = 1; @(negedge clk); cmd_resume = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset cs_active", cs_active, 0);
        chk("R1 reset status", status, 0);
        chk("R1 reset irq", irq, 0);

        // gapped transfer: 2 packets of 3 bytes, idle 4 cycles
        start(2, 1, 3, 0, 0);
        chk("R1 cs after activate", cs_active, 1);
        chk("R1 byte_req after activate", byte_req, 1);
        wait_done();
        chk("R2 byte total 3x2", nbytes, 6);
        chk("R3 idle gap cycles", ngap, 4);
        chk("R7 irq gated by finish_ie", irq, 0);
        finish_ie = 1;
        @(negedge clk);
        chk("R7 irq with finish_ie", irq, 1);
        status_rd_clr = 1; @(negedge clk); status_rd_clr = 0;
        chk("R6 done cleared by read strobe", status, 0);
        chk("R7 irq drops after clear", irq, 0);

        // streaming, slow acks, activate with new length mid-run
        ack_mode = 2;
        start(3, 2, 5, 0, 1);
        repeat (4) @(negedge clk);
        pkt_len_m1 = 0; pkt_loop_m1 = 0; cmd_act = 1;
        @(negedge clk); cmd_act = 0;
        wait_done();
        chk("R9 R10 bytes unchanged by late activate", nbytes, 12);
        chk("R4 no gap in streaming mode", ngap, 0);
        chk("R6 done set", status, 1);
        ack_mode = 0;
        start(0, 0, 0, 0, 0);
        chk("R6 done cleared by activate", status[0], 0);
        ack_mode = 1;
        wait_done();
        chk("R2 single byte transfer", nbytes, 1);

        // pause mode
        finish_ie = 0; pause_ie = 1;
        start(1, 2, 2, 1, 0);
        wait_paused();
        chk("R5 cs off while paused", cs_active, 0);
        chk("R7 pause irq", irq, 1);
        repeat (5) @(negedge clk);
        chk("R5 stays paused", status, 2);
        @(negedge clk); cmd_act = 1; @(negedge clk); cmd_act = 0;
        chk("R9 activate ignored while paused", status, 2);
        chk("R9 cs still off", cs_active, 0);
        pulse_resume();
        chk("R5 resume clears paused bit", status[1], 0);
        wait_paused();
        pulse_resume();
        wait_done();
        chk("R5 bytes with pauses", nbytes, 6);
        chk("R5 done at end, not paused", status, 1);
        pause_ie = 0;

        // resume in idle is ignored
        pulse_resume();
        chk("R9 resume ignored in idle", cs_active, 0);
        @(negedge clk);
        chk("R9 still idle", byte_req, 0);

        // software reset mid-transfer
        start(7, 3, 1, 0, 0);
        repeat (10) @(negedge clk);
        cmd_swrst = 1; @(negedge clk); cmd_swrst = 0; in_x = 0;
        chk("R8 swrst drops cs", cs_active, 0);
        chk("R8 swrst clears status", status, 0);
        repeat (20) @(negedge clk);
        chk("R8 stays idle after abort", byte_req, 0);

        // extremes
        start(0, 255, 0, 0, 1);
        wait_done();
        chk("R11 256 one-byte packets", nbytes, 256);
        start(16'hFFFF, 0, 0, 0, 0);
        wait_done();
        chk("R11 65536-byte packet", nbytes, 65536);

        repeat (3) @(negedge clk);
        report();
    end
endmodule